// File: doc/BRIEF.md
# Weight-Stationary Systolic 1-D Convolver

This block computes a four-tap one-dimensional convolution over a stream of signed samples. It is a straight line of four identical cells, each permanently holding one coefficient. Samples travel along the line from the input end, one cell per advance. Partial sums travel the other way, from the far end towards the output end, and each cell adds one product to the sum that passes through it. A finished sum leaves the cell nearest the input. Every cell registers both its sample and its partial sum, so no path crosses more than one multiply and one add.

Samples enter through a valid/ready port and results leave through a valid/ready port. The block places its own bubble after every accepted sample, so samples inside the array are always two advances apart. With that spacing, each partial sum meets the four consecutive samples of its window exactly once. A partial sum is injected at the far end on every advance. Only the ones that met four valid samples come out flagged valid. The others carry valid low and the output logic ignores them.

Back-pressure works as follows. While a result is offered and out_ready is low, the whole array freezes and in_ready stays low. If a sample slot passes with no valid input, the slot becomes an empty sample, and no result is produced for any window that spans it. Coefficients are written through a small write port before streaming starts. Reset does not touch them.

Top module: `sysconv_line`

## Requirements
- R1: Each result equals w0·x(i) + w1·x(i+1) + w2·x(i+2) + w3·x(i+3), where x(i) is the oldest sample of the window and wk is the coefficient written at index k. The arithmetic is exact in 18-bit two's complement, including the products of -128 by -128 and of 127 by -128.
- R2: Results leave in increasing window order. N accepted samples in back-to-back sample slots give exactly N-3 results and no others.
- R3: A sample is accepted only in a sample slot. After a handshake on the input, in_ready is low in the next cycle, because a bubble slot always follows. Valid samples and bubbles alternate along the whole array.
- R4: With out_ready high, the result of a window appears with out_valid high in the cycle right after the handshake of that window's newest sample. out_valid never rises without an input handshake in the previous cycle.
- R5: While out_valid is high and out_ready is low, out_data and out_valid hold and in_ready is low. No data is lost or duplicated.
- R6: A sample slot in which in_valid is low, while in_ready is high, becomes an empty slot with zero data. No result is produced for a window that spans it. Windows that lie wholly after it are produced normally.
- R7: A synchronous active-high rst empties the array: out_valid is low and in_ready is high after it. Nothing accepted before reset contributes to any later result. Coefficients keep their values.
- R8: A write with wt_we high stores wt_data as coefficient wt_idx. Index 0 is the tap for the oldest sample of the window and index 3 the tap for the newest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wt_we | input | 1 | Coefficient write strobe |
| wt_idx | input | 2 | Tap index of the coefficient write |
| wt_data | input | 8 | Signed coefficient value |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample slot open and output not blocked |
| in_data | input | 8 | Signed sample |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Result taken |
| out_data | output | 18 | Signed convolution result |

## Verification
The bench builds the default configuration: four taps, 8-bit samples and coefficients, and 18-bit sums. It is small enough to sweep every sample value through the array and to drive the product extremes into all four cells at once. With six coefficient sets, it covers a one-hot set that exposes the tap order and sets that saturate the 18-bit range in both signs. It also exercises periodic and irregular output stalls, an idle sample slot in the middle of a stream and a reset in the middle of a stream. Each result is compared with a convolution computed in plain integer arithmetic, together with its cycle of arrival whenever the output is never stalled.

// File: rtl/sysconv_pkg.sv
`timescale 1ns/1ps
package sysconv_pkg;

  // Phase of the array: samples enter only in SLOT_SAMPLE, and every
  // advance flips the phase so that a bubble trails each sample.
  typedef enum logic {
    SLOT_SAMPLE = 1'b0,
    SLOT_BUBBLE = 1'b1
  } slot_e;

endpackage

// File: rtl/sysconv_slot_ctrl.sv
`timescale 1ns/1ps
module sysconv_slot_ctrl
  import sysconv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic adv,
  output logic take
);

  slot_e slot_q;
  logic  blocked;

  // A result that cannot leave freezes the entire line.
  assign blocked  = out_valid & ~out_ready;
  assign adv      = ~blocked;
  assign in_ready = (slot_q == SLOT_SAMPLE) & ~blocked;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SLOT_SAMPLE;
    end else if (adv) begin
      slot_q <= (slot_q == SLOT_SAMPLE) ? SLOT_BUBBLE : SLOT_SAMPLE;
    end
  end

endmodule

// File: rtl/sysconv_cell.sv
`timescale 1ns/1ps
module sysconv_cell #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 18,
  parameter int IDX_W  = 2,
  parameter int TAP_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              wt_we,
  input  logic [IDX_W-1:0]  wt_idx,
  input  logic [COEF_W-1:0] wt_data,
  input  logic [DATA_W-1:0] x_in,
  input  logic              xv_in,
  output logic [DATA_W-1:0] x_out,
  output logic              xv_out,
  input  logic [ACC_W-1:0]  ps_in,
  input  logic              pv_in,
  output logic [ACC_W-1:0]  ps_out,
  output logic              pv_out
);

  logic [COEF_W-1:0]       coef_q;
  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] c_ext;
  logic signed [ACC_W-1:0] prod;

  // Stationary coefficient, written once before streaming.
  always_ff @(posedge clk) begin
    if (wt_we && (wt_idx == IDX_W'(TAP_ID))) begin
      coef_q <= wt_data;
    end
  end

  // Sign-extend before multiplying so the product keeps full precision.
  assign x_ext = ACC_W'($signed(x_in));
  assign c_ext = ACC_W'($signed(coef_q));
  assign prod  = x_ext * c_ext;

  // Sample moves on, partial sum picks up this cell's product.
  always_ff @(posedge clk) begin
    if (rst) begin
      x_out  <= '0;
      xv_out <= 1'b0;
      ps_out <= '0;
      pv_out <= 1'b0;
    end else if (adv) begin
      x_out  <= x_in;
      xv_out <= xv_in;
      ps_out <= ps_in + prod;
      pv_out <= pv_in & xv_in;
    end
  end

endmodule

// File: rtl/sysconv_line.sv
`timescale 1ns/1ps
module sysconv_line #(
  parameter  int DATA_W = 8,
  parameter  int COEF_W = 8,
  parameter  int TAPS   = 4,
  localparam int IDX_W  = $clog2(TAPS),
  localparam int ACC_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wt_we,
  input  logic [IDX_W-1:0]  wt_idx,
  input  logic [COEF_W-1:0] wt_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_data
);

  logic adv;
  logic take;
  logic tail_v;
  logic [DATA_W-1:0] tail_x;

  // Sample buses run from index 0 (input end) upward;
  // partial-sum buses run from index TAPS (far end) downward.
  logic [DATA_W-1:0] x_bus  [0:TAPS];
  logic              xv_bus [0:TAPS];
  logic [ACC_W-1:0]  ps_bus [0:TAPS];
  logic              pv_bus [0:TAPS];

  sysconv_slot_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .adv       (adv),
    .take      (take)
  );

  // Bubble slots carry zero data so that no stale sample rides along.
  assign x_bus[0]     = take ? in_data : '0;
  assign xv_bus[0]    = take;
  assign ps_bus[TAPS] = '0;
  assign pv_bus[TAPS] = 1'b1;

  // The cell at the input end meets the newest sample of each window,
  // so it holds the highest tap index.
  for (genvar c = 0; c < TAPS; c++) begin : g_cell
    sysconv_cell #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W),
      .IDX_W  (IDX_W),
      .TAP_ID (TAPS - 1 - c)
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .wt_we   (wt_we),
      .wt_idx  (wt_idx),
      .wt_data (wt_data),
      .x_in    (x_bus[c]),
      .xv_in   (xv_bus[c]),
      .x_out   (x_bus[c+1]),
      .xv_out  (xv_bus[c+1]),
      .ps_in   (ps_bus[c+1]),
      .pv_in   (pv_bus[c+1]),
      .ps_out  (ps_bus[c]),
      .pv_out  (pv_bus[c])
    );
  end

  assign tail_v    = xv_bus[TAPS];
  assign tail_x    = x_bus[TAPS];
  assign out_valid = pv_bus[0];
  assign out_data  = ps_bus[0];

endmodule

// File: rtl/sysconv_line_chk.sv
`timescale 1ns/1ps
module sysconv_line_chk #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ACC_W-1:0]  out_data,
  input logic              tail_v,
  input logic [DATA_W-1:0] tail_x
);

  // R7: reset leaves the array empty and open for a sample
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  // R3: a bubble slot follows every accepted sample
  a_r3_spacing: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R3: samples and bubbles still alternate at the far end
  a_r3_far_end_spacing: assert property (@(posedge clk) disable iff (rst)
    (tail_v && !(out_valid && !out_ready)) |=> !tail_v);

  // R5: a stalled result holds its value
  a_r5_hold_data: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5: nothing enters while the output is stalled
  a_r5_no_intake: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R4: a new result follows an input handshake by one cycle
  a_r4_follows_sample: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R6: empty slots carry zero data all the way down the line
  a_r6_bubble_zero: assert property (@(posedge clk) disable iff (rst)
    !tail_v |-> (tail_x == '0));

endmodule

bind sysconv_line sysconv_line_chk #(
  .DATA_W (DATA_W),
  .ACC_W  (ACC_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .tail_v    (tail_v),
  .tail_x    (tail_x)
);

// File: tb/test_sysconv_line.sv
`timescale 1ns/1ps
module test_sysconv_line;

  localparam int N_SAMP = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wt_we = 1'b0;
  logic [1:0]  wt_idx = '0;
  logic [7:0]  wt_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [17:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int wv [4];
  int exp_q [$];
  int due_q [$];
  int h0, h1, h2, run;
  int emitted;

  always #2.5 clk = ~clk;

  sysconv_line i_sysconv_line (
    .clk       (clk),
    .rst       (rst),
    .wt_we     (wt_we),
    .wt_idx    (wt_idx),
    .wt_data   (wt_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    report();
  end

  function automatic int gen(input int set, input int j);
    case (set)
      0:       return (j % 256) - 128;
      1:       return -128;
      2:       return (j % 2 == 1) ? 127 : -128;
      default: return ((j * j * 7 + j * 61 + set * 113) % 256) - 128;
    endcase
  endfunction

  function automatic int wgen(input int set, input int k);
    case (set)
      0:       return (k == 0) ? 1 : (k == 1) ? -2 : (k == 2) ? 3 : -4;
      1:       return -128;
      2:       return (k % 2 == 1) ? -128 : 127;
      3:       return (k == 2) ? 1 : 0;
      4:       return (k == 0) ? -1 : (k == 1) ? 5 : (k == 2) ? -7 : 100;
      default: return (k == 0) ? -128 : (k == 1) ? 127 : (k == 2) ? 0 : -1;
    endcase
  endfunction

  function automatic bit orpat(input int set, input int c);
    case (set)
      0, 1:    return 1'b1;
      2:       return (c % 3) != 0;
      3:       return (c % 5) != 1;
      4:       return ((c * 13) % 7) > 1;
      default: return (c % 4) != 2;
    endcase
  endfunction

  task automatic model_push(input int x);
    if (run >= 3) begin
      exp_q.push_back(wv[0] * h0 + wv[1] * h1 + wv[2] * h2 + wv[3] * x);
      due_q.push_back(cyc + 1);
    end
    h0 = h1;
    h1 = h2;
    h2 = x;
    run++;
  endtask

  task automatic load_weights(input int set);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      wv[k]   = wgen(set, k);
      wt_we   = 1'b1;
      wt_idx  = 2'(k);
      wt_data = 8'(wv[k]);
    end
    @(negedge clk);
    wt_we = 1'b0;
  endtask

  task automatic run_set(input int set);
    int  j = 0;
    int  tail = 0;
    bit  gap_done = 1'b0;
    bit  rst_done = 1'b0;
    bit  prev_acc = 1'b0;
    bit  prev_blk = 1'b0;
    int  prev_data = 0;
    int  val;
    int  want;
    string req;
    load_weights(set);
    run = 0;
    emitted = 0;
    exp_q.delete();
    due_q.delete();
    req = (set == 3) ? "R8" : "R1";
    while (j < N_SAMP || exp_q.size() > 0 || tail < 4) begin
      if (set == 5 && j == 30 && !rst_done) begin
        // R7: reset in the middle of a stream
        @(negedge clk);
        cyc++;
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        cyc++;
        rst = 1'b0;
        #1;
        chk(!out_valid, "R7 out_valid after mid-stream reset", int'(out_valid), 0);
        chk(in_ready, "R7 in_ready after mid-stream reset", int'(in_ready), 1);
        rst_done = 1'b1;
        exp_q.delete();
        due_q.delete();
        run = 0;
        emitted = 0;
        prev_acc = 1'b0;
        prev_blk = 1'b0;
        continue;
      end
      @(negedge clk);
      cyc++;
      out_ready = orpat(set, cyc);
      in_valid  = (j < N_SAMP) && !(set == 4 && j == 50 && !gap_done);
      in_data   = 8'(gen(set, j));
      #1;
      if (prev_acc) chk(!in_ready, "R3 bubble after accepted sample", int'(in_ready), 0);
      if (prev_blk) begin
        chk(out_valid && ($signed(out_data) == prev_data), "R5 stalled result held",
            int'($signed(out_data)), prev_data);
      end
      if (out_valid && !out_ready) chk(!in_ready, "R5 no intake while stalled", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        val = int'($signed(out_data));
        emitted++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected result", val, 0);
        end else begin
          chk(val == exp_q[0], req, val, exp_q[0]);
          if (set <= 1) chk(cyc == due_q[0], "R4 result cycle", cyc, due_q[0]);
          void'(exp_q.pop_front());
          void'(due_q.pop_front());
        end
      end
      prev_blk  = out_valid && !out_ready;
      prev_data = int'($signed(out_data));
      prev_acc  = in_valid && in_ready;
      if (in_valid && in_ready) begin
        model_push(gen(set, j));
        j++;
      end else if (!in_valid && in_ready) begin
        // R6: an unused sample slot breaks the window sequence
        run = 0;
        if (set == 4 && j == 50) gap_done = 1'b1;
      end
      if (j >= N_SAMP && exp_q.size() == 0) tail++;
    end
    in_valid = 1'b0;
    if (set == 4) want = N_SAMP - 6;
    else if (set == 5) want = N_SAMP - 33;
    else want = N_SAMP - 3;
    chk(emitted == want, (set == 4) ? "R6 result count around gap" :
        (set == 5) ? "R7 result count after reset" : "R2 result count", emitted, want);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid, "R7 out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R7 in_ready after reset", int'(in_ready), 1);
    for (int s = 0; s < 6; s++) run_set(s);
    report();
  end

endmodule